// File: doc/BRIEF.md
# OFDM Frame Airtime Calculator

This block works out how long an OFDM frame occupies the air, in microseconds. A caller presents the frame length in bytes, the bit rate in steps of 100 kbit/s and a channel-width mode, then pulses a start strobe. The block adds the inter-frame gap, the preamble and the time of a whole number of symbols, and returns the sum with a one-cycle done pulse after a fixed number of cycles. The symbol count is found by a sequential restoring divider and then rounded up. The rounding covers the header bits plus eight bits per byte.

The same engine fills an acknowledgement-timeout table. Given a transmit-rate index and a switch that permits fast acknowledgements, the block picks the rate index at which the acknowledgement is sent. On an acknowledgement request it computes the airtime of a 10-byte acknowledgement at that rate. The chosen index is also shown combinationally so that the caller can address its own table.

Top module: `airtime_calc`

## Requirements
- R1: After a synchronous active-low reset, busy_o, done_o, err_o and dur_o are all zero.
- R2: With bw_mode_i = 0 (20 MHz), dur_o = 16 + 16 + 4 × ceil((22 + 8 × len_i) × 10 / (rate_i × 4)). The gap is 16 µs, the preamble 16 µs, the symbol 4 µs and the header 22 bits.
- R3: With bw_mode_i = 2 (10 MHz), the preamble becomes 32 µs and the symbol 8 µs, and the gap is 32 µs.
- R4: With bw_mode_i = 3 (5 MHz), the preamble becomes 64 µs and the symbol 16 µs, and the gap is 64 µs.
- R5: With bw_mode_i = 1 (40 MHz turbo), the preamble is 8 µs, the gap is 8 µs and the symbol stays 4 µs.
- R6: The symbol count rounds up only when the division leaves a remainder. An exact quotient is used as it is.
- R7: A request is accepted at a clock edge where busy_o is low. busy_o is then high until done_o pulses for exactly one cycle, 21 clock edges after the accepting edge (the dividend width plus one). dur_o changes only together with done_o.
- R8: A start or acknowledgement request raised while busy_o is high is ignored. The running result and its timing are unchanged, and no further done_o pulse follows.
- R9: rate_i = 0 gives err_o = 1 and dur_o = 0 at done_o. The next job with a nonzero rate clears err_o.
- R10: With ack_high_i = 1, ack_idx_o maps tx_idx_i 0..11 to 0,1,1,1,4,4,6,6,8,8,8,8, and maps indices 12..15 to 8.
- R11: With ack_high_i = 0, ack_idx_o is 0 for tx_idx_i 0..3 and 4 for every other index.
- R12: An acknowledgement request (ack_start_i) computes the airtime of a 10-byte frame in the current bw_mode_i. It uses the rate of ack_idx_o, taken from the index-to-rate list 10,20,55,110,60,90,120,180,240,360,480,540 (×100 kbit/s).
- R13: If start_i and ack_start_i are both high at an accepting edge, the data-frame request wins and the acknowledgement request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Data-frame request strobe |
| ack_start_i | input | 1 | Acknowledgement-airtime request strobe |
| len_i | input | 12 | Frame length in bytes |
| rate_i | input | 10 | Bit rate in units of 100 kbit/s |
| bw_mode_i | input | 2 | 0: 20 MHz, 1: 40 MHz turbo, 2: 10 MHz, 3: 5 MHz |
| tx_idx_i | input | 4 | Transmit-rate index for the acknowledgement map |
| ack_high_i | input | 1 | Permit fast acknowledgement rates |
| ack_idx_o | output | 4 | Acknowledgement-rate index chosen for tx_idx_i |
| busy_o | output | 1 | A computation is in progress |
| done_o | output | 1 | One-cycle result strobe |
| dur_o | output | 29 | Airtime in microseconds |
| err_o | output | 1 | Last result came from a zero rate |

## Verification
The data-frame path and the acknowledgement path share one divider, so both requests can arrive in the same cycle. Each can also arrive while a job is still running. The bench raises start_i and ack_start_i on the same edge and expects a result that matches the data-frame formula, not the 10-byte figure. It also fires a second request in the middle of a running job. There it expects the first job's value at the first job's latency and no extra done pulse afterwards.

// File: rtl/airtime_pkg.sv
// Package: shared mode encoding and rate-index lookups for the airtime
// calculator. Assumes rate indices 0..11 and rates in units of 100 kbit/s.
package airtime_pkg;

    typedef enum logic [1:0] {
        BW_20      = 2'd0,
        BW_40TURBO = 2'd1,
        BW_10      = 2'd2,
        BW_5       = 2'd3
    } bw_mode_e;

    localparam int IDX_W  = 4;
    localparam int TBL_RW = 10;

    // Maps a transmit-rate index to the rate index used for its acknowledgement.
    function automatic logic [IDX_W-1:0] ack_map(input logic [IDX_W-1:0] idx,
                                                 input logic high);
        logic [IDX_W-1:0] r;
        if (high) begin
            case (idx)
                4'd0:                r = 4'd0;
                4'd1, 4'd2, 4'd3:    r = 4'd1;
                4'd4, 4'd5:          r = 4'd4;
                4'd6, 4'd7:          r = 4'd6;
                default:             r = 4'd8;
            endcase
        end else begin
            r = (idx < 4'd4) ? 4'd0 : 4'd4;
        end
        return r;
    endfunction

    // Returns the bit rate (x100 kbit/s) of a rate index.
    function automatic logic [TBL_RW-1:0] rate_of_idx(input logic [IDX_W-1:0] idx);
        logic [TBL_RW-1:0] r;
        case (idx)
            4'd0:    r = 10'd10;
            4'd1:    r = 10'd20;
            4'd2:    r = 10'd55;
            4'd3:    r = 10'd110;
            4'd4:    r = 10'd60;
            4'd5:    r = 10'd90;
            4'd6:    r = 10'd120;
            4'd7:    r = 10'd180;
            4'd8:    r = 10'd240;
            4'd9:    r = 10'd360;
            4'd10:   r = 10'd480;
            default: r = 10'd540;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/airtime_mode_sel.sv
// Module: picks the inter-frame gap, preamble and symbol time for a channel
// width mode. Purely combinational; assumes the scaled constants fit T_W bits.
module airtime_mode_sel
    import airtime_pkg::*;
#(
    parameter int T_W          = 8,
    parameter int PRE_US       = 16,
    parameter int PRE_MIN_US   = 8,
    parameter int SYM_US       = 4,
    parameter int SIFS_US      = 16,
    parameter int SIFS_TURBO   = 8,
    parameter int SIFS_HALF    = 32,
    parameter int SIFS_QUARTER = 64
) (
    input  logic [1:0]     mode_i,
    output logic [T_W-1:0] pre_o,
    output logic [T_W-1:0] sym_o,
    output logic [T_W-1:0] sifs_o
);

    // Selects and scales the timing constants for the requested mode.
    always_comb begin
        case (bw_mode_e'(mode_i))
            BW_40TURBO: begin
                pre_o  = T_W'(PRE_MIN_US);
                sym_o  = T_W'(SYM_US);
                sifs_o = T_W'(SIFS_TURBO);
            end
            BW_10: begin
                pre_o  = T_W'(PRE_US * 2);
                sym_o  = T_W'(SYM_US * 2);
                sifs_o = T_W'(SIFS_HALF);
            end
            BW_5: begin
                pre_o  = T_W'(PRE_US * 4);
                sym_o  = T_W'(SYM_US * 4);
                sifs_o = T_W'(SIFS_QUARTER);
            end
            default: begin
                pre_o  = T_W'(PRE_US);
                sym_o  = T_W'(SYM_US);
                sifs_o = T_W'(SIFS_US);
            end
        endcase
    end

endmodule

// File: rtl/airtime_divider.sv
// Module: sequential restoring divider, one quotient bit per cycle.
// A start loads the operands; done_o pulses NUM_W edges later with the
// quotient and a remainder-nonzero flag. Assumes den_i is nonzero and that
// start_i is raised only while busy_o is low.
module airtime_divider #(
    parameter int NUM_W = 20,
    parameter int DEN_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o,
    output logic             rem_nz_o
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             done_q;
    logic [DEN_W:0]   shifted;
    logic             fits;

    // Forms the shifted partial remainder and compares it with the divisor.
    always_comb begin
        shifted = {rem_q, quo_q[NUM_W-1]};
        fits    = (shifted >= {1'b0, den_q});
    end

    // Loads operands, then retires one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !run_q) begin
                quo_q <= num_i;
                rem_q <= '0;
                den_q <= den_i;
                cnt_q <= CNT_W'(NUM_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? DEN_W'(shifted - {1'b0, den_q}) : shifted[DEN_W-1:0];
                quo_q <= {quo_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o   = run_q;
    assign done_o   = done_q;
    assign quo_o    = quo_q;
    assign rem_nz_o = |rem_q;

endmodule

// File: rtl/airtime_ack_sel.sv
// Module: chooses the acknowledgement rate index for a transmit index and
// the bit rate that index stands for. Combinational; assumes RATE_W >= 10.
module airtime_ack_sel
    import airtime_pkg::*;
#(
    parameter int RATE_W = 10
) (
    input  logic [IDX_W-1:0]  tx_idx_i,
    input  logic              high_i,
    output logic [IDX_W-1:0]  ack_idx_o,
    output logic [RATE_W-1:0] ack_rate_o
);

    // Applies the index map and looks up the rate of the chosen index.
    always_comb begin
        ack_idx_o  = ack_map(tx_idx_i, high_i);
        ack_rate_o = RATE_W'(rate_of_idx(ack_idx_o));
    end

endmodule

// File: rtl/airtime_calc.sv
// Module: top of the OFDM airtime calculator. Accepts a data-frame or a
// 10-byte acknowledgement request while idle (data wins a tie), divides the
// bit count into whole symbols and returns gap + preamble + symbol time.
// Assumes inputs are held stable only during the accepting cycle.
module airtime_calc
    import airtime_pkg::*;
#(
    parameter int LEN_W        = 12,
    parameter int RATE_W       = 10,
    parameter int T_W          = 8,
    parameter int PLCP_BITS    = 22,
    parameter int ACK_BYTES    = 10,
    parameter int PRE_US       = 16,
    parameter int PRE_MIN_US   = 8,
    parameter int SYM_US       = 4,
    parameter int SIFS_US      = 16,
    parameter int SIFS_TURBO   = 8,
    parameter int SIFS_HALF    = 32,
    parameter int SIFS_QUARTER = 64,
    localparam int BITS_W      = LEN_W + 4,
    localparam int NUM_W       = BITS_W + 4,
    localparam int DEN_W       = RATE_W + T_W,
    localparam int DUR_W       = T_W + NUM_W + 1,
    localparam int LATENCY     = NUM_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ack_start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [1:0]        bw_mode_i,
    input  logic [3:0]        tx_idx_i,
    input  logic              ack_high_i,
    output logic [3:0]        ack_idx_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DUR_W-1:0]  dur_o,
    output logic              err_o
);

    logic [T_W-1:0]    pre_w, sym_w, sifs_w;
    logic [RATE_W-1:0] ack_rate_w;
    logic              accept, use_ack;
    logic [LEN_W-1:0]  eff_len;
    logic [RATE_W-1:0] eff_rate;
    logic [BITS_W-1:0] bits_w;
    logic [NUM_W-1:0]  num_w;
    logic [DEN_W-1:0]  den_w;
    logic              div_busy, div_done, div_rem_nz;
    logic [NUM_W-1:0]  div_quo;

    logic              busy_q, done_q, err_q, zero_q;
    logic [T_W:0]      base_q;
    logic [T_W-1:0]    sym_q;
    logic [DUR_W-1:0]  dur_q;
    logic [NUM_W:0]    sym_count;

    airtime_mode_sel #(
        .T_W          (T_W),
        .PRE_US       (PRE_US),
        .PRE_MIN_US   (PRE_MIN_US),
        .SYM_US       (SYM_US),
        .SIFS_US      (SIFS_US),
        .SIFS_TURBO   (SIFS_TURBO),
        .SIFS_HALF    (SIFS_HALF),
        .SIFS_QUARTER (SIFS_QUARTER)
    ) u_mode (
        .mode_i (bw_mode_i),
        .pre_o  (pre_w),
        .sym_o  (sym_w),
        .sifs_o (sifs_w)
    );

    airtime_ack_sel #(
        .RATE_W (RATE_W)
    ) u_ack (
        .tx_idx_i   (tx_idx_i),
        .high_i     (ack_high_i),
        .ack_idx_o  (ack_idx_o),
        .ack_rate_o (ack_rate_w)
    );

    // Arbitrates the two request kinds and forms the divider operands.
    always_comb begin
        accept   = !busy_q && (start_i || ack_start_i);
        use_ack  = !start_i && ack_start_i;
        eff_len  = use_ack ? LEN_W'(ACK_BYTES) : len_i;
        eff_rate = use_ack ? ack_rate_w : rate_i;
        bits_w   = BITS_W'(PLCP_BITS) + (BITS_W'(eff_len) << 3);
        num_w    = NUM_W'(bits_w) * NUM_W'(10);
        den_w    = (eff_rate == '0) ? DEN_W'(1)
                                    : DEN_W'(eff_rate) * DEN_W'(sym_w);
    end

    airtime_divider #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept),
        .num_i    (num_w),
        .den_i    (den_w),
        .busy_o   (div_busy),
        .done_o   (div_done),
        .quo_o    (div_quo),
        .rem_nz_o (div_rem_nz)
    );

    // Rounds the quotient up to whole symbols when a remainder is left.
    always_comb begin
        sym_count = {1'b0, div_quo} + (NUM_W + 1)'(div_rem_nz);
    end

    // Tracks the job, captures the per-job constants and registers the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            zero_q <= 1'b0;
            base_q <= '0;
            sym_q  <= '0;
            dur_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                zero_q <= (eff_rate == '0);
                base_q <= {1'b0, sifs_w} + {1'b0, pre_w};
                sym_q  <= sym_w;
            end else if (busy_q && div_done) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                err_q  <= zero_q;
                dur_q  <= zero_q ? '0
                        : DUR_W'(base_q) + DUR_W'(sym_q) * DUR_W'(sym_count);
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign dur_o  = dur_q;
    assign err_o  = err_q;

endmodule

// File: rtl/airtime_calc_chk.sv
// Checker: temporal rules of the airtime calculator, seen at its ports.
// Counts edges since acceptance to check the fixed latency without deep $past.
module airtime_calc_chk #(
    parameter int LATENCY = 21,
    parameter int DUR_W   = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             ack_start_i,
    input logic [3:0]       tx_idx_i,
    input logic             ack_high_i,
    input logic [3:0]       ack_idx_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [DUR_W-1:0] dur_o,
    input logic             err_o
);

    localparam int LC_W = $clog2(LATENCY + 3) + 1;
    logic [LC_W-1:0] lat_cnt;

    // Counts edges since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_cnt <= '0;
        else if (!busy_o && (start_i || ack_start_i))
            lat_cnt <= LC_W'(1);
        else if (busy_o)
            lat_cnt <= lat_cnt + 1'b1;
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_cnt == LC_W'(LATENCY + 1)));

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R8
    dur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> ($stable(dur_o) || done_o));

    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (dur_o == '0));

    // R10
    ack_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_high_i |-> (ack_idx_o <= 4'd8));

    // R11
    ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_high_i |-> (ack_idx_o == ((tx_idx_i < 4'd4) ? 4'd0 : 4'd4)));

endmodule

bind airtime_calc airtime_calc_chk #(
    .LATENCY (LATENCY),
    .DUR_W   (DUR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ack_start_i (ack_start_i),
    .tx_idx_i    (tx_idx_i),
    .ack_high_i  (ack_high_i),
    .ack_idx_o   (ack_idx_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .dur_o       (dur_o),
    .err_o       (err_o)
);

// File: tb/tb_airtime_calc.sv
// Directed bench for the airtime calculator; one task per scenario.
module tb_airtime_calc;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 12;
    localparam int LAT        = LEN_W + 8 + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        ack_start_i = 1'b0;
    logic [11:0] len_i = '0;
    logic [9:0]  rate_i = '0;
    logic [1:0]  bw_mode_i = '0;
    logic [3:0]  tx_idx_i = '0;
    logic        ack_high_i = 1'b0;
    logic [3:0]  ack_idx_o;
    logic        busy_o, done_o, err_o;
    logic [28:0] dur_o;

    int checks = 0;
    int fails  = 0;

    int rate_tbl[12] = '{10, 20, 55, 110, 60, 90, 120, 180, 240, 360, 480, 540};
    int hi_map[16]   = '{0, 1, 1, 1, 4, 4, 6, 6, 8, 8, 8, 8, 8, 8, 8, 8};

    airtime_calc dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_start_i(ack_start_i),
        .len_i(len_i), .rate_i(rate_i), .bw_mode_i(bw_mode_i),
        .tx_idx_i(tx_idx_i), .ack_high_i(ack_high_i), .ack_idx_o(ack_idx_o),
        .busy_o(busy_o), .done_o(done_o), .dur_o(dur_o), .err_o(err_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Airtime from the stated formula.
    function automatic int expect_dur(input int len, input int rate, input int mode);
        int pre, sym, gap, bits, den;
        pre = 16; sym = 4; gap = 16;
        if (mode == 1) begin pre = 8; gap = 8; end
        if (mode == 2) begin pre = 32; sym = 8; gap = 32; end
        if (mode == 3) begin pre = 64; sym = 16; gap = 64; end
        bits = (22 + 8 * len) * 10;
        den  = rate * sym;
        return gap + pre + sym * ((bits + den - 1) / den);
    endfunction

    // Issues one request and waits for done; returns result and edge count.
    task automatic run_job(input bit s, input bit a, input int len, input int rate,
                           input int mode, input int tx, input bit hi,
                           output int dur, output bit err, output int edges);
        @(negedge clk);
        start_i = s; ack_start_i = a;
        len_i = 12'(len); rate_i = 10'(rate); bw_mode_i = 2'(mode);
        tx_idx_i = 4'(tx); ack_high_i = hi;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0; ack_start_i = 1'b0;
        edges = 0;
        while (!done_o && edges < LAT + 10) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        dur = int'(dur_o);
        err = err_o;
    endtask

    task automatic t_reset;
        check(!busy_o && !done_o && !err_o && dur_o == 0, "R1 reset state",
              int'(dur_o) + int'(busy_o) + int'(done_o) + int'(err_o), 0);
    endtask

    task automatic t_modes;
        int d, e; bit er;
        run_job(1, 0, 100, 60, 0, 0, 0, d, er, e);
        check(d == expect_dur(100, 60, 0), "R2 20MHz len100 6M", d, expect_dur(100, 60, 0));
        check(e == LAT, "R7 latency", e, LAT);
        check(!busy_o, "R7 busy low at done", int'(busy_o), 0);
        run_job(1, 0, 1500, 540, 0, 0, 0, d, er, e);
        check(d == expect_dur(1500, 540, 0), "R2 20MHz len1500 54M", d, expect_dur(1500, 540, 0));
        run_job(1, 0, 200, 120, 2, 0, 0, d, er, e);
        check(d == expect_dur(200, 120, 2), "R3 10MHz", d, expect_dur(200, 120, 2));
        run_job(1, 0, 200, 120, 3, 0, 0, d, er, e);
        check(d == expect_dur(200, 120, 3), "R4 5MHz", d, expect_dur(200, 120, 3));
        run_job(1, 0, 200, 120, 1, 0, 0, d, er, e);
        check(d == expect_dur(200, 120, 1), "R5 turbo", d, expect_dur(200, 120, 1));
        run_job(1, 0, 4095, 1, 3, 0, 0, d, er, e);
        check(d == expect_dur(4095, 1, 3), "R2 max length min rate", d, expect_dur(4095, 1, 3));
    endtask

    task automatic t_ceiling;
        int d, e; bit er;
        run_job(1, 0, 10, 255, 0, 0, 0, d, er, e);
        check(d == 36, "R6 exact division", d, 36);
        run_job(1, 0, 10, 254, 0, 0, 0, d, er, e);
        check(d == 40, "R6 remainder rounds up", d, 40);
    endtask

    task automatic t_zero_rate;
        int d, e; bit er;
        run_job(1, 0, 50, 0, 0, 0, 0, d, er, e);
        check(er == 1'b1, "R9 error flag", int'(er), 1);
        check(d == 0, "R9 zero duration", d, 0);
        run_job(1, 0, 50, 60, 0, 0, 0, d, er, e);
        check(er == 1'b0, "R9 error cleared", int'(er), 0);
    endtask

    task automatic t_busy_ignore;
        int edges, dones; int first;
        first = expect_dur(300, 90, 0);
        @(negedge clk);
        start_i = 1; len_i = 12'd300; rate_i = 10'd90; bw_mode_i = 2'd0;
        @(posedge clk);
        @(negedge clk);
        start_i = 0;
        edges = 0;
        repeat (3) begin @(posedge clk); edges++; @(negedge clk); end
        start_i = 1; ack_start_i = 1; len_i = 12'd7; rate_i = 10'd540; bw_mode_i = 2'd3;
        @(posedge clk); edges++; @(negedge clk);
        start_i = 0; ack_start_i = 0;
        while (!done_o && edges < LAT + 10) begin
            @(posedge clk); edges++; @(negedge clk);
        end
        check(edges == LAT, "R8 latency kept", edges, LAT);
        check(int'(dur_o) == first, "R8 first result kept", int'(dur_o), first);
        dones = 0;
        repeat (LAT + 4) begin
            @(posedge clk); @(negedge clk);
            if (done_o) dones++;
        end
        check(dones == 0, "R8 no extra done", dones, 0);
        check(!busy_o, "R8 idle afterwards", int'(busy_o), 0);
    endtask

    task automatic t_ack_map;
        int bad_hi = 0, bad_lo = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            tx_idx_i = 4'(i); ack_high_i = 1'b1;
            #1;
            if (int'(ack_idx_o) != hi_map[i]) bad_hi++;
            ack_high_i = 1'b0;
            #1;
            if (int'(ack_idx_o) != ((i < 4) ? 0 : 4)) bad_lo++;
        end
        check(bad_hi == 0, "R10 fast map mismatches", bad_hi, 0);
        check(bad_lo == 0, "R11 base map mismatches", bad_lo, 0);
    endtask

    task automatic t_ack_job;
        int d, e, exp; bit er;
        exp = expect_dur(10, rate_tbl[hi_map[11]], 0);
        run_job(0, 1, 999, 7, 0, 11, 1, d, er, e);
        check(d == exp, "R12 ack fast idx11", d, exp);
        exp = expect_dur(10, rate_tbl[0], 2);
        run_job(0, 1, 999, 7, 2, 2, 0, d, er, e);
        check(d == exp, "R12 ack base idx2 10MHz", d, exp);
        exp = expect_dur(10, rate_tbl[4], 0);
        run_job(0, 1, 0, 0, 0, 6, 0, d, er, e);
        check(d == exp && !er, "R12 ack base idx6", d, exp);
    endtask

    task automatic t_collision;
        int d, e, exp; bit er;
        exp = expect_dur(400, 180, 0);
        run_job(1, 1, 400, 180, 0, 11, 1, d, er, e);
        check(d == exp, "R13 data request wins", d, exp);
        check(e == LAT, "R13 latency", e, LAT);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_modes;
        t_ceiling;
        t_zero_rate;
        t_busy_ignore;
        t_ack_map;
        t_ack_job;
        t_collision;
        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule